// File: doc/BRIEF.md
# Mask-Driven Register Transfer Sequencer

This block moves 32-bit words between a local bank of sixteen general registers and a coprocessor operand port. The bank holds eight data registers and eight address registers. Each job starts from a 16-bit primitive word. The block then fetches a 16-bit select mask and walks through the registers whose mask bit is set, one word per register. One flag in the primitive word picks the direction. When the flag is clear, register contents stream out to the operand port. When the flag is set, words stream in from the port and overwrite the selected registers.

Every data path at the edge uses valid/ready: the primitive input, the mask fetch, the outbound operand stream and the inbound operand stream. A transfer happens only on a cycle where valid and ready are both high. Back-pressure is allowed at any time and may last any number of cycles. While a word is stalled, the outbound valid, the outbound data and the current register index all hold steady. The inbound ready also stays high and the index does not move.

The block also checks whether the primitive is legal for the instruction category that is running. If it is not, the block raises a protocol-violation flag and does no work.

Top module: `regxfer_seq`

## Requirements
- R1: A primitive is taken on a clock edge where `prim_valid` and `prim_ready` are both high, and `prim_ready` is high only while the block is idle. Bit 15 of `prim_word` is the coprocessor-acknowledge flag and bit 13 is the direction flag. Bit 14 and bits 12..0 have no effect.
- R2: After a legal primitive is taken, the block raises `mask_ready` and waits for `mask_valid`. It asserts neither `out_valid` nor `in_ready` until the mask has been taken.
- R3: Mask bit n selects the register with index n. Indices 0..7 are data registers D0..D7 and indices 8..15 are address registers A0..A7. Only registers whose bit is 1 take part, and `cur_idx` shows the index of the register being moved.
- R4: Selected registers are visited in the order D7 down to D0, then A7 down to A0, and this order is the same for both directions.
- R5: With the direction flag at 0, each selected register is offered on `out_data` with `out_valid` high. The data, `out_valid` and `cur_idx` hold unchanged until `out_ready` is seen.
- R6: With the direction flag at 1, `in_ready` is high for each selected register. The word on `in_data` is written into that register on the edge where `in_valid` is high, and `cur_idx` holds until then.
- R7: A primitive with bit 15 at 0 that is taken while `cond_cat` is 1 sets `proto_viol` in the next cycle and leaves the block idle. No mask fetch, no transfer, no `done` and no register change follows. The flag stays set until the next primitive is taken or reset is applied.
- R8: An all-zero mask ends the job right after the mask is taken, with no operand transfer, and `done` pulses.
- R9: `done` is high for exactly one cycle. That cycle follows the edge of the last handshake, and `prim_ready` is already high in it, so a waiting primitive is taken at the next edge.
- R10: `prim_valid` has no effect while a job is running, whatever the primitive word or `cond_cat` holds.
- R11: Synchronous active-high `rst` returns the block to idle, clears `proto_viol` and `done`, and zeroes all sixteen registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prim_valid | input | 1 | Primitive word offered |
| prim_ready | output | 1 | Block idle, primitive can be taken |
| prim_word | input | 16 | Primitive word (bit 15 acknowledge, bit 13 direction) |
| cond_cat | input | 1 | A conditional-category instruction is running |
| mask_valid | input | 1 | Select mask offered |
| mask_ready | output | 1 | Block waiting for the select mask |
| mask_data | input | 16 | Register select mask |
| out_valid | output | 1 | Outbound operand offered |
| out_ready | input | 1 | Operand port takes the outbound word |
| out_data | output | DATA_W | Outbound register contents |
| in_valid | input | 1 | Inbound operand offered |
| in_ready | output | 1 | Block takes an inbound word |
| in_data | input | DATA_W | Inbound operand |
| cur_idx | output | 4 | Index of the register being moved |
| done | output | 1 | One-cycle end-of-job pulse |
| proto_viol | output | 1 | Protocol-violation flag |

## Verification
Two events can land in the same cycle: the `done` pulse that ends one job, and the taking of the next primitive. The bench provokes this by raising `prim_valid` with a new word together with the final handshake of a job. In the following cycle it expects `done` and `prim_ready` both high. One cycle later it expects `mask_ready` high with `done` low, which shows the new job started right behind the old one. Separately, a bad primitive is driven into a busy block in the middle of a stall. The bench checks that the job keeps its order and data and that `proto_viol` stays low.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;
  localparam int REG_CNT = 16;
  localparam int HALF    = REG_CNT / 2;
  localparam int IDX_W   = $clog2(REG_CNT);
  localparam int PW_W    = 16;
  localparam int CA_BIT  = 15;
  localparam int DR_BIT  = 13;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MASK = 2'd1,
    ST_XFER = 2'd2
  } seq_state_e;

  // Scan step s -> register index: data half high to low, then address half high to low.
  function automatic logic [IDX_W-1:0] scan_to_idx(input int s);
    if (s < HALF) return IDX_W'(HALF - 1 - s);
    else          return IDX_W'(REG_CNT - 1 - (s - HALF));
  endfunction
endpackage

// File: rtl/regxfer_bank.sv
module regxfer_bank
  import regxfer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] regs_q [REG_CNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_CNT; i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign rdata = regs_q[raddr];
endmodule

// File: rtl/regxfer_pick.sv
module regxfer_pick
  import regxfer_pkg::*;
(
  input  logic [REG_CNT-1:0] sel,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  logic [REG_CNT-1:0] scan;
  logic [IDX_W-1:0]   first;

  // Reorder the mask into visiting order so a plain priority search finds the next register.
  for (genvar s = 0; s < REG_CNT; s++) begin : g_perm
    assign scan[s] = sel[scan_to_idx(s)];
  end

  always_comb begin
    any   = 1'b0;
    first = '0;
    for (int s = REG_CNT - 1; s >= 0; s--) begin
      if (scan[s]) begin
        any   = 1'b1;
        first = IDX_W'(s);
      end
    end
  end

  assign idx = scan_to_idx(int'(first));
endmodule

// File: rtl/regxfer_ctrl.sv
module regxfer_ctrl
  import regxfer_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               prim_valid,
  input  logic [PW_W-1:0]    prim_word,
  input  logic               cond_cat,
  input  logic               mask_valid,
  input  logic [REG_CNT-1:0] mask_data,
  input  logic               out_ready,
  input  logic               in_valid,
  input  logic [IDX_W-1:0]   cur_idx,
  output logic               prim_ready,
  output logic               mask_ready,
  output logic               out_valid,
  output logic               in_ready,
  output logic               bank_we,
  output logic [REG_CNT-1:0] rem_q,
  output logic               done,
  output logic               proto_viol
);
  seq_state_e         state_q;
  logic               dr_q;
  logic               done_q;
  logic               viol_q;
  logic               ca;
  logic               dr;
  logic               illegal;
  logic               hs;
  logic [REG_CNT-1:0] rem_next;
  logic               unused_prim;

  assign ca          = prim_word[CA_BIT];
  assign dr          = prim_word[DR_BIT];
  assign unused_prim = ^{prim_word[CA_BIT-1:DR_BIT+1], prim_word[DR_BIT-1:0]};
  assign illegal     = !ca && cond_cat;

  assign prim_ready = (state_q == ST_IDLE);
  assign mask_ready = (state_q == ST_MASK);
  assign out_valid  = (state_q == ST_XFER) && !dr_q;
  assign in_ready   = (state_q == ST_XFER) && dr_q;
  assign hs         = dr_q ? (in_ready && in_valid) : (out_valid && out_ready);
  assign bank_we    = in_ready && in_valid;
  assign rem_next   = rem_q & ~(REG_CNT'(1) << cur_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      dr_q    <= 1'b0;
      rem_q   <= '0;
      done_q  <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (prim_valid) begin
            dr_q <= dr;
            if (illegal) begin
              viol_q <= 1'b1;
            end else begin
              viol_q  <= 1'b0;
              state_q <= ST_MASK;
            end
          end
        end
        ST_MASK: begin
          if (mask_valid) begin
            rem_q <= mask_data;
            if (mask_data == '0) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_XFER;
            end
          end
        end
        ST_XFER: begin
          if (hs) begin
            rem_q <= rem_next;
            if (rem_next == '0) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign proto_viol = viol_q;
endmodule

// File: rtl/regxfer_seq.sv
module regxfer_seq
  import regxfer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prim_valid,
  output logic              prim_ready,
  input  logic [15:0]       prim_word,
  input  logic              cond_cat,
  input  logic              mask_valid,
  output logic              mask_ready,
  input  logic [15:0]       mask_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [3:0]        cur_idx,
  output logic              done,
  output logic              proto_viol
);
  logic [REG_CNT-1:0] rem_q;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_any;
  logic               bank_we;
  logic               unused_any;

  assign unused_any = pick_any;

  regxfer_pick u_pick (
    .sel (rem_q),
    .any (pick_any),
    .idx (pick_idx)
  );

  regxfer_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .prim_valid (prim_valid),
    .prim_word  (prim_word),
    .cond_cat   (cond_cat),
    .mask_valid (mask_valid),
    .mask_data  (mask_data),
    .out_ready  (out_ready),
    .in_valid   (in_valid),
    .cur_idx    (pick_idx),
    .prim_ready (prim_ready),
    .mask_ready (mask_ready),
    .out_valid  (out_valid),
    .in_ready   (in_ready),
    .bank_we    (bank_we),
    .rem_q      (rem_q),
    .done       (done),
    .proto_viol (proto_viol)
  );

  regxfer_bank #(.DATA_W(DATA_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (bank_we),
    .waddr (pick_idx),
    .wdata (in_data),
    .raddr (pick_idx),
    .rdata (out_data)
  );

  assign cur_idx = pick_idx;
endmodule

// File: rtl/regxfer_seq_chk.sv
module regxfer_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              prim_valid,
  input logic              prim_ready,
  input logic [15:0]       prim_word,
  input logic              cond_cat,
  input logic              mask_valid,
  input logic              mask_ready,
  input logic [15:0]       mask_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        cur_idx,
  input logic              done,
  input logic              proto_viol
);
  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    prim_valid && prim_ready && (prim_word[15] || !cond_cat) |=> mask_ready && !proto_viol);

  p_mask_first_r2: assert property (@(posedge clk) disable iff (rst)
    mask_ready |-> !out_valid && !in_ready);

  p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(cur_idx));

  p_in_hold_r6: assert property (@(posedge clk) disable iff (rst)
    in_ready && !in_valid |=> in_ready && $stable(cur_idx));

  p_dir_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && in_ready));

  p_viol_r7: assert property (@(posedge clk) disable iff (rst)
    prim_valid && prim_ready && !prim_word[15] && cond_cat |=> proto_viol && prim_ready);

  p_zero_mask_r8: assert property (@(posedge clk) disable iff (rst)
    mask_valid && mask_ready && (mask_data == 16'h0) |=> done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> prim_ready);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    prim_ready |-> !out_valid && !in_ready && !mask_ready);
endmodule

bind regxfer_seq regxfer_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .prim_valid (prim_valid),
  .prim_ready (prim_ready),
  .prim_word  (prim_word),
  .cond_cat   (cond_cat),
  .mask_valid (mask_valid),
  .mask_ready (mask_ready),
  .mask_data  (mask_data),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .cur_idx    (cur_idx),
  .done       (done),
  .proto_viol (proto_viol)
);

// File: tb/regxfer_seq_tb.sv
module regxfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prim_valid = 1'b0;
  logic        prim_ready;
  logic [15:0] prim_word = '0;
  logic        cond_cat = 1'b0;
  logic        mask_valid = 1'b0;
  logic        mask_ready;
  logic [15:0] mask_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [3:0]  cur_idx;
  logic        done;
  logic        proto_viol;

  int tests = 0;
  int fails = 0;
  int seq   = 0;
  logic [31:0] model [16];

  always #5 clk = ~clk;

  regxfer_seq u_dut (
    .clk(clk), .rst(rst), .prim_valid(prim_valid), .prim_ready(prim_ready),
    .prim_word(prim_word), .cond_cat(cond_cat), .mask_valid(mask_valid),
    .mask_ready(mask_ready), .mask_data(mask_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .cur_idx(cur_idx), .done(done),
    .proto_viol(proto_viol)
  );

  // {ca, pc, cond_cat, dr, mask}
  localparam logic [19:0] VEC [10] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF},  // R11 readback of cleared bank
    {1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF},  // R6 load all
    {1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF},  // R1 pc bit set, read all
    {1'b1, 1'b0, 1'b0, 1'b1, 16'h8001},  // R3 A7 and D0
    {1'b1, 1'b0, 1'b0, 1'b0, 16'hA5C3},  // R10 noise while busy
    {1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},  // R8 empty mask
    {1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF},  // R7 illegal
    {1'b0, 1'b1, 1'b0, 1'b1, 16'h00F0},  // R1 ca=0 legal outside conditional
    {1'b1, 1'b0, 1'b1, 1'b0, 16'h0F0F},  // R1 ca=1 legal inside conditional
    {1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF}   // R7 bank untouched by illegal job
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && !prim_ready; i++) @(negedge clk);
  endtask

  task automatic run_prim(input logic ca, input logic pc, input logic cnd, input logic dr,
                          input logic [15:0] msk, input bit noise, input bit chain);
    int order [16];
    int n = 0;
    for (int s = 0; s < 16; s++) begin
      int ix = (s < 8) ? (7 - s) : (23 - s);
      if (msk[ix]) begin order[n] = ix; n++; end
    end
    wait_idle();
    prim_word  = {ca, pc, dr, 13'h1ABC};
    cond_cat   = cnd;
    prim_valid = 1'b1;
    @(negedge clk);
    prim_valid = 1'b0;
    if (!ca && cnd) begin
      check(proto_viol && prim_ready && !mask_ready, "R7", "flag/idle",
            {29'd0, proto_viol, prim_ready, mask_ready}, 32'h6);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check(!out_valid && !in_ready && !done && !mask_ready && proto_viol, "R7", "quiet",
              {28'd0, out_valid, in_ready, done, proto_viol}, 32'h1);
      end
      return;
    end
    check(mask_ready && !out_valid && !in_ready && !proto_viol, "R2", "mask first",
          {28'd0, mask_ready, out_valid, in_ready, proto_viol}, 32'h8);
    mask_data  = msk;
    mask_valid = 1'b1;
    @(negedge clk);
    mask_valid = 1'b0;
    if (n == 0) begin
      check(done && prim_ready && !out_valid && !in_ready, "R8", "empty done",
            {28'd0, done, prim_ready, out_valid, in_ready}, 32'hC);
      @(negedge clk);
      check(!done, "R9", "pulse width", {31'd0, done}, 32'h0);
      return;
    end
    for (int k = 0; k < n; k++) begin
      int stalls = (k + seq) % 3;
      logic [31:0] val = 32'h5A00_0000 | (32'(seq) << 16) | (32'(k) << 8) | 32'(order[k]);
      for (int st = 0; st < stalls; st++) begin
        if (noise && st == 0) begin
          prim_valid = 1'b1;
          prim_word  = {1'b0, 1'b0, ~dr, 13'h0};
          cond_cat   = 1'b1;
        end
        if (dr) check(in_ready && cur_idx == 4'(order[k]), "R6", "stall hold idx",
                      {27'd0, in_ready, cur_idx}, 32'h10 | 32'(order[k]));
        else    check(out_valid && cur_idx == 4'(order[k]) && out_data == model[order[k]],
                      "R5", "stall hold data", out_data, model[order[k]]);
        @(negedge clk);
        if (noise) begin
          prim_valid = 1'b0;
          cond_cat   = cnd;
          check(!proto_viol && !prim_ready, "R10", "busy ignores prim",
                {30'd0, proto_viol, prim_ready}, 32'h0);
        end
      end
      if (dr) begin
        check(in_ready && cur_idx == 4'(order[k]), "R4", "in order idx",
              {27'd0, in_ready, cur_idx}, 32'h10 | 32'(order[k]));
        in_data  = val;
        in_valid = 1'b1;
        model[order[k]] = val;
      end else begin
        check(out_valid && cur_idx == 4'(order[k]), "R4", "out order idx",
              {27'd0, out_valid, cur_idx}, 32'h10 | 32'(order[k]));
        check(out_data == model[order[k]], "R5", "out data", out_data, model[order[k]]);
        out_ready = 1'b1;
      end
      if (chain && k == n - 1) begin
        prim_valid = 1'b1;
        prim_word  = 16'h8000;
        cond_cat   = 1'b0;
      end
      @(negedge clk);
      out_ready = 1'b0;
      in_valid  = 1'b0;
    end
    check(done && prim_ready, "R9", "done after last",
          {30'd0, done, prim_ready}, 32'h3);
    @(negedge clk);
    if (chain) begin
      prim_valid = 1'b0;
      check(mask_ready && !done, "R9", "next prim taken in done cycle",
            {30'd0, mask_ready, done}, 32'h2);
      mask_data  = 16'h0000;
      mask_valid = 1'b1;
      @(negedge clk);
      mask_valid = 1'b0;
      check(done, "R8", "chained empty job", {31'd0, done}, 32'h1);
      @(negedge clk);
    end else begin
      check(!done, "R9", "pulse width", {31'd0, done}, 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(prim_ready && !done && !proto_viol && !out_valid && !in_ready && !mask_ready,
          "R11", "reset state",
          {26'd0, prim_ready, done, proto_viol, out_valid, in_ready, mask_ready}, 32'h20);

    for (int v = 0; v < 10; v++) begin
      seq = v;
      run_prim(VEC[v][19], VEC[v][18], VEC[v][17], VEC[v][16], VEC[v][15:0], v == 4, 1'b0);
    end

    // R9: next primitive meets the done cycle
    seq = 11;
    run_prim(1'b1, 1'b0, 1'b0, 1'b1, 16'h0100, 1'b0, 1'b1);

    // R11: reset clears a raised flag and the bank
    seq = 12;
    run_prim(1'b0, 1'b0, 1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0);
    check(proto_viol, "R7", "flag held", {31'd0, proto_viol}, 32'h1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!proto_viol && prim_ready && !done, "R11", "reset clears flag",
          {29'd0, proto_viol, prim_ready, done}, 32'h2);
    for (int i = 0; i < 16; i++) model[i] = '0;
    seq = 13;
    run_prim(1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule